// File: doc/BRIEF.md
# I2C Master Receive Sequencer

This block runs the data phase of an I2C master read once the address has been sent and acknowledged. It generates SCL from the system clock and samples SDA on each rising SCL edge, most significant bit first. It answers every byte on the ninth clock with either an acknowledge or a not-acknowledge, as set by a software acknowledge bit. When the ninth clock is over, it moves the byte into a data register and raises a receive-not-empty flag.

If software has not read the previous byte by the time a new byte is complete, the controller sets a byte-finished flag. It then keeps SCL low until the data register is read. Ending the transfer is armed one byte early. Software clears the acknowledge bit and asks for a stop or a repeated start right after reading the second-to-last byte. The controller then sends a not-acknowledge on the last byte and closes the bus after it. For a single-byte read, software arms both together with the receive start strobe.

Top module: `i2c_master_rx`

## Requirements
- R1: Eight data bits are sampled from the SDA input at each rising SCL edge (sclLow falling), most significant bit first. The completed byte appears on rxData.
- R2: During the high phase of the ninth clock, sdaLow equals the value of ackEn when that high phase began. A value of 1 is an acknowledge and 0 (SDA released) is a not-acknowledge.
- R3: rxNotEmpty goes to 1 when a byte is moved into rxData at the end of its ninth clock. A dataRead pulse with byteFinished at 0 clears it.
- R4: If rxNotEmpty is still 1 when a byte's ninth clock ends, byteFinished goes to 1 and SCL is held low. A dataRead pulse then loads the held byte into rxData, clears byteFinished, leaves rxNotEmpty at 1 and resumes clocking.
- R5: irq is 1 exactly when rxNotEmpty, evtIrqEn and bufIrqEn are all 1.
- R6: A stopReq pulse makes the controller issue a stop once the next not-acknowledged byte has completed. SDA is released while SCL is high, and masterMode then reads 0.
- R7: A restartReq pulse makes the controller issue a repeated start after the next not-acknowledged byte. SDA is pulled low while SCL is high, restartDone pulses for one cycle, and masterMode stays 1.
- R8: ackEn at 0 and stopReq given together with rxStart produce exactly one byte, not-acknowledged, followed by a stop.
- R9: After a not-acknowledged byte with no pending request, SCL is held low and masterMode stays 1 until stopReq or restartReq arrives.
- R10: After reset, sclLow, sdaLow, rxNotEmpty, byteFinished, irq and masterMode are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxStart | input | 1 | Pulse: address phase done, begin receiving |
| ackEn | input | 1 | Software acknowledge control bit |
| stopReq | input | 1 | Pulse: arm a stop after the next not-acknowledged byte |
| restartReq | input | 1 | Pulse: arm a repeated start after the next not-acknowledged byte |
| dataRead | input | 1 | Pulse: software reads the data register |
| evtIrqEn | input | 1 | Event interrupt enable |
| bufIrqEn | input | 1 | Buffer interrupt enable |
| sdaIn | input | 1 | Sensed SDA bus level |
| sclLow | output | 1 | 1 pulls SCL low |
| sdaLow | output | 1 | 1 pulls SDA low |
| rxData | output | 8 | Data register |
| rxNotEmpty | output | 1 | Receive-not-empty flag |
| byteFinished | output | 1 | Byte-finished flag (bus stalled) |
| irq | output | 1 | Receive interrupt request |
| masterMode | output | 1 | Controller holds master role |
| restartDone | output | 1 | One-cycle pulse after a repeated start |

## Verification
Transfers of random length from one to six bytes carry random data. The byte values separate correct bit order and framing from shifted or reversed capture. Software read latency is chosen at random per byte, either prompt or longer than a whole byte. The prompt reads check the plain flag handshake, and the long ones force the stalled case and the release of the held byte. Each transfer ends in a stop or a repeated start, picked at random with random interrupt enables, which separates the two closing sequences and the interrupt gating. Directed single-byte reads and a late close request cover arming at the start strobe and the idle hold after a not-acknowledge.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

  typedef struct packed {
    logic shiftBit;    // sample SDA into the shift register
    logic finishByte;  // ninth clock over: hand byte to data register
  } dpCtrlT;

  typedef enum logic [3:0] {
    ST_IDLE, ST_BITLOW, ST_BITHIGH, ST_ACKLOW, ST_ACKHIGH,
    ST_STALL, ST_HOLD, ST_STOPA, ST_STOPB, ST_STOPC,
    ST_RSA, ST_RSB, ST_RSC
  } rxStateT;

endpackage

// File: rtl/i2c_rx_datapath.sv
module i2c_rx_datapath
  import i2c_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrlT            ctl,
  input  logic              sdaIn,
  input  logic              dataRead,
  input  logic              evtIrqEn,
  input  logic              bufIrqEn,
  output logic [DATA_W-1:0] rxData,
  output logic              rxne,
  output logic              btf,
  output logic              irq
);

  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (ctl.shiftBit) shiftReg <= {shiftReg[DATA_W-2:0], sdaIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      rxne   <= 1'b0;
      btf    <= 1'b0;
    end else if (ctl.finishByte) begin
      if (rxne && !dataRead) begin
        btf <= 1'b1;
      end else begin
        rxData <= shiftReg;
        rxne   <= 1'b1;
      end
    end else if (dataRead) begin
      if (btf) begin
        rxData <= shiftReg;
        btf    <= 1'b0;
      end else begin
        rxne <= 1'b0;
      end
    end
  end

  assign irq = rxne & evtIrqEn & bufIrqEn;

  // R4: byte-finished only ever accompanies an unread data register
  a_r4_btf_with_rxne: assert property (@(posedge clk) disable iff (!rstN)
    btf |-> rxne);

  // R4: a read while stalled releases the stall and keeps the new byte flagged
  a_r4_read_releases: assert property (@(posedge clk) disable iff (!rstN)
    (btf && dataRead && !ctl.finishByte) |=> (!btf && rxne));

  // R3: a plain read empties the data register flag
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && rxne && !btf && !ctl.finishByte) |=> !rxne);

endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import i2c_rx_pkg::*;
#(
  parameter int HALF_CYCLES = 4,
  parameter int DATA_W      = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   rxStart,
  input  logic   ackEn,
  input  logic   stopReq,
  input  logic   restartReq,
  input  logic   dataRead,
  input  logic   rxne,
  input  logic   btf,
  output dpCtrlT ctl,
  output logic   sclLow,
  output logic   sdaLow,
  output logic   masterMode,
  output logic   restartDone
);

  localparam int CNT_W = $clog2(HALF_CYCLES + 1);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  rxStateT          state;
  logic [CNT_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             tick, waitState, ackLatched, stopPend, rsPend;
  rxStateT          afterAck;

  assign tick      = (divCnt == CNT_W'(HALF_CYCLES - 1));
  assign waitState = (state == ST_IDLE) || (state == ST_STALL) || (state == ST_HOLD);

  always_comb begin
    if (ackLatched)    afterAck = ST_BITLOW;
    else if (stopPend) afterAck = ST_STOPA;
    else if (rsPend)   afterAck = ST_RSA;
    else               afterAck = ST_HOLD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (tick || waitState) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopPend <= 1'b0;
      rsPend   <= 1'b0;
    end else begin
      if (state == ST_STOPA || state == ST_RSA) begin
        stopPend <= 1'b0;
        rsPend   <= 1'b0;
      end
      if (stopReq)    stopPend <= 1'b1;
      if (restartReq) rsPend   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      bitCnt      <= '0;
      ackLatched  <= 1'b0;
      masterMode  <= 1'b0;
      restartDone <= 1'b0;
    end else begin
      restartDone <= 1'b0;
      unique case (state)
        ST_IDLE: if (rxStart) begin
          state      <= ST_BITLOW;
          bitCnt     <= '0;
          masterMode <= 1'b1;
        end
        ST_BITLOW:  if (tick) state <= ST_BITHIGH;
        ST_BITHIGH: if (tick) begin
          if (bitCnt == LAST_BIT) state <= ST_ACKLOW;
          else begin
            bitCnt <= bitCnt + 1'b1;
            state  <= ST_BITLOW;
          end
        end
        ST_ACKLOW: if (tick) begin
          ackLatched <= ackEn;
          state      <= ST_ACKHIGH;
        end
        ST_ACKHIGH: if (tick) begin
          bitCnt <= '0;
          state  <= (rxne && !dataRead) ? ST_STALL : afterAck;
        end
        ST_STALL: if (dataRead) state <= afterAck;
        ST_HOLD: begin
          if (stopPend)    state <= ST_STOPA;
          else if (rsPend) state <= ST_RSA;
        end
        ST_STOPA: if (tick) state <= ST_STOPB;
        ST_STOPB: if (tick) state <= ST_STOPC;
        ST_STOPC: if (tick) begin
          state      <= ST_IDLE;
          masterMode <= 1'b0;
        end
        ST_RSA: if (tick) state <= ST_RSB;
        ST_RSB: if (tick) state <= ST_RSC;
        ST_RSC: if (tick) begin
          state       <= ST_IDLE;
          restartDone <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.shiftBit   = (state == ST_BITLOW) && tick;
    ctl.finishByte = (state == ST_ACKHIGH) && tick;
    sclLow = 1'b0;
    sdaLow = 1'b0;
    unique case (state)
      ST_IDLE:    begin sclLow = masterMode; sdaLow = masterMode; end
      ST_BITLOW, ST_STALL, ST_HOLD, ST_RSA: sclLow = 1'b1;
      ST_ACKLOW:  begin sclLow = 1'b1; sdaLow = ackEn; end
      ST_ACKHIGH: sdaLow = ackLatched;
      ST_STOPA:   begin sclLow = 1'b1; sdaLow = 1'b1; end
      ST_STOPB, ST_RSC: sdaLow = 1'b1;
      default: ;
    endcase
  end

  // R4: while the data register overflows, SCL stays pulled low
  a_r4_stall_holds_scl: assert property (@(posedge clk) disable iff (!rstN)
    btf |-> sclLow);

  // R2: the acknowledge level does not move during the ninth clock's high phase
  a_r2_ack_stable: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACKHIGH && $past(state == ST_ACKHIGH)) |-> $stable(sdaLow));

  // R6: leaving master mode leaves both lines released
  a_r6_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    $fell(masterMode) |-> (!sclLow && !sdaLow));

  // R7: a repeated start keeps the master role
  a_r7_restart_master: assert property (@(posedge clk) disable iff (!rstN)
    restartDone |-> masterMode);

endmodule

// File: rtl/i2c_master_rx.sv
module i2c_master_rx
  import i2c_rx_pkg::*;
#(
  parameter int HALF_CYCLES = 4,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxStart,
  input  logic              ackEn,
  input  logic              stopReq,
  input  logic              restartReq,
  input  logic              dataRead,
  input  logic              evtIrqEn,
  input  logic              bufIrqEn,
  input  logic              sdaIn,
  output logic              sclLow,
  output logic              sdaLow,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNotEmpty,
  output logic              byteFinished,
  output logic              irq,
  output logic              masterMode,
  output logic              restartDone
);

  dpCtrlT ctl;

  i2c_rx_ctrl #(.HALF_CYCLES(HALF_CYCLES), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxStart(rxStart), .ackEn(ackEn),
    .stopReq(stopReq), .restartReq(restartReq), .dataRead(dataRead),
    .rxne(rxNotEmpty), .btf(byteFinished), .ctl(ctl),
    .sclLow(sclLow), .sdaLow(sdaLow), .masterMode(masterMode),
    .restartDone(restartDone)
  );

  i2c_rx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaIn(sdaIn), .dataRead(dataRead),
    .evtIrqEn(evtIrqEn), .bufIrqEn(bufIrqEn), .rxData(rxData),
    .rxne(rxNotEmpty), .btf(byteFinished), .irq(irq)
  );

endmodule

// File: tb/i2c_master_rx_tb.sv
module i2c_master_rx_tb;

  localparam int HALF = 4;
  localparam int LONG_WAIT = 100;

  logic clk = 1'b0, rstN = 1'b0;
  logic rxStart = 0, ackEn = 1, stopReq = 0, restartReq = 0, dataRead = 0;
  logic evtIrqEn = 0, bufIrqEn = 0, slaveSda = 1;
  logic sdaBus, sclLow, sdaLow, rxNotEmpty, byteFinished, irq, masterMode, restartDone;
  logic [7:0] rxData;

  logic [7:0] txBytes [0:7];
  int nBytes = 1;
  int checks = 0, failures = 0;
  int ackChecks = 0, ackFails = 0, stopSeen = 0, rsSeen = 0, rdSeen = 0;

  always #4 clk = ~clk;  // 125 MHz

  assign sdaBus = slaveSda & ~sdaLow;

  i2c_master_rx #(.HALF_CYCLES(HALF), .DATA_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .rxStart(rxStart), .ackEn(ackEn),
    .stopReq(stopReq), .restartReq(restartReq), .dataRead(dataRead),
    .evtIrqEn(evtIrqEn), .bufIrqEn(bufIrqEn), .sdaIn(sdaBus),
    .sclLow(sclLow), .sdaLow(sdaLow), .rxData(rxData),
    .rxNotEmpty(rxNotEmpty), .byteFinished(byteFinished), .irq(irq),
    .masterMode(masterMode), .restartDone(restartDone)
  );

  // slave model and bus monitor
  logic prevScl = 0, prevSda = 0, active = 0;
  int bitIdx = 0, byteIdx = 0;
  always @(negedge clk) begin
    if (rxStart) begin
      active  = 1;
      byteIdx = 0;
      bitIdx  = sclLow ? 0 : -1;
      slaveSda = txBytes[0][7];
    end else if (active) begin
      if (sclLow && !prevScl) begin
        bitIdx++;
        if (bitIdx == 9) begin
          byteIdx++;
          bitIdx = 0;
        end
        if (bitIdx < 8) slaveSda = txBytes[byteIdx][7-bitIdx];
        else slaveSda = 1'b1;
      end else if (!sclLow && prevScl && bitIdx == 8) begin
        ackChecks++;
        if (sdaLow !== (byteIdx < nBytes - 1)) begin
          ackFails++;
          $display("FAIL R2 byte %0d ack: actual=%0b expected=%0b",
                   byteIdx, sdaLow, (byteIdx < nBytes - 1));
        end
        if (byteIdx == nBytes - 1) begin
          active = 0;
          slaveSda = 1'b1;
        end
      end
    end
    if (!sclLow && !prevScl && prevSda && !sdaLow) stopSeen++;
    if (!sclLow && !prevScl && !prevSda && sdaLow) rsSeen++;
    if (restartDone) rdSeen++;
    prevScl = sclLow;
    prevSda = sdaLow;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit expIrq(input bit ne, input bit e1, input bit e2);
    return ne & e1 & e2;
  endfunction

  task automatic pulseRequest(input bit useRestart);
    @(negedge clk);
    if (useRestart) restartReq = 1; else stopReq = 1;
    @(negedge clk);
    restartReq = 0;
    stopReq = 0;
  endtask

  task automatic doTransfer(input int n, input bit useRestart, input bit lateReq);
    int stop0, rs0, rd0, waitCnt;
    bit stalled;
    nBytes = n;
    for (int k = 0; k < n; k++) txBytes[k] = 8'($urandom);
    evtIrqEn = 1'($urandom);
    bufIrqEn = 1'($urandom);
    stop0 = stopSeen; rs0 = rsSeen; rd0 = rdSeen;
    @(negedge clk);
    rxStart = 1;
    ackEn = (n > 1);
    if (n == 1 && !lateReq) begin
      if (useRestart) restartReq = 1; else stopReq = 1;  // R8 arming with start
    end
    @(negedge clk);
    rxStart = 0; stopReq = 0; restartReq = 0;
    for (int i = 0; i < n; i++) begin
      waitCnt = 0;
      while (!rxNotEmpty && waitCnt < 2000) begin
        @(negedge clk);
        waitCnt++;
      end
      check(rxNotEmpty, "R3 byte arrives", rxNotEmpty, 1);
      check(irq == expIrq(rxNotEmpty, evtIrqEn, bufIrqEn), "R5 irq", irq,
            expIrq(rxNotEmpty, evtIrqEn, bufIrqEn));
      stalled = (i <= n - 3) && ($urandom % 3 == 0);
      if (stalled) begin
        repeat (LONG_WAIT) @(negedge clk);
        check(byteFinished && sclLow, "R4 stall", {byteFinished, sclLow}, 2'b11);
      end else begin
        repeat ($urandom % 3) @(negedge clk);
      end
      check(rxData == txBytes[i], "R1 data", rxData, txBytes[i]);
      dataRead = 1;
      @(negedge clk);
      dataRead = 0;
      if (stalled)
        check(!byteFinished && rxNotEmpty && rxData == txBytes[i+1], "R4 release",
              {byteFinished, rxNotEmpty, rxData}, {2'b01, txBytes[i+1]});
      else
        check(!rxNotEmpty, "R3 read clears", rxNotEmpty, 0);
      if (i == n - 2) begin
        ackEn = 0;
        if (!lateReq) pulseRequest(useRestart);
      end
    end
    if (lateReq) begin
      repeat (40) @(negedge clk);
      check(sclLow && masterMode && stopSeen == stop0 && rsSeen == rs0, "R9 hold",
            {sclLow, masterMode}, 2'b11);
      pulseRequest(useRestart);
    end
    waitCnt = 0;
    while (stopSeen == stop0 && rsSeen == rs0 && waitCnt < 500) begin
      @(negedge clk);
      waitCnt++;
    end
    repeat (2 * HALF) @(negedge clk);
    if (useRestart) begin
      check(rsSeen == rs0 + 1 && stopSeen == stop0, "R7 repeated start", rsSeen - rs0, 1);
      check(masterMode && rdSeen == rd0 + 1, "R7 master kept", {masterMode, 8'(rdSeen - rd0)}, 9'h101);
    end else begin
      check(stopSeen == stop0 + 1 && rsSeen == rs0,
            n == 1 ? "R8 single byte stop" : "R6 stop", stopSeen - stop0, 1);
      check(!masterMode && !sclLow && !sdaLow, "R6 released", {masterMode, sclLow, sdaLow}, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h1CE5));
    repeat (3) @(negedge clk);
    check({sclLow, sdaLow, rxNotEmpty, byteFinished, irq, masterMode} == 6'b0,
          "R10 reset state", {sclLow, sdaLow, rxNotEmpty, byteFinished, irq, masterMode}, 0);
    rstN = 1;
    @(negedge clk);
    doTransfer(1, 0, 0);          // R8 single byte with stop
    doTransfer(1, 1, 0);          // single byte with repeated start
    doTransfer(2, 0, 1);          // R9 late request
    doTransfer(5, 1, 0);
    for (int t = 0; t < 20; t++)
      doTransfer(1 + ($urandom % 6), 1'($urandom), 1'($urandom % 5 == 0));
    check(ackFails == 0 && ackChecks > 0, "R2 ack totals", ackFails, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + ackChecks, failures + ackFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + ackChecks + 1, failures + ackFails + 1);
    $finish;
  end

endmodule